// File: doc/BRIEF.md
# Fault Cause Query Engine

This block lets a motor-drive controller find out which protection shut the power stage down, using only the six gate-command inputs it already drives. While the fault line is asserted, the controller sets every command input high to put the block into a query state. In that state all gate outputs, the auxiliary output and the clear-timer node are held low. The controller then presents one query pattern on the low-side inputs, waits a fixed delay, and samples the shared open-drain fault pin. A pulled-low pin means the selected cause bit is set.

Each query pattern keeps all high-side inputs high and drives exactly one low-side input low, or all of them low. Each pattern selects one bit of the cause register. The controller leaves the query state by keeping the low-side inputs high and dropping the high-side inputs. A command pattern is acted on only after it has been stable for `STABLE_CYC` clock cycles, so short noise on the command lines cannot enter, leave or answer anything. The cause register is kept outside this block and is only read here. Its bits are set by trip events and cleared when the automatic fault clear ends, never by a query.

Top module: `fault_query_engine`

## Requirements
- R1: With `faultActive` low, the all-high command pattern does not enter the query state. `diagActive` stays 0.
- R2: With `faultActive` high, the query state is entered (`diagActive`=1) once all high-side and all low-side command inputs have been high together for the stability window.
- R3: While `diagActive` is 1, `driveHold` is 1. This forces the gate outputs and the auxiliary output low and holds the clear-timer node low. Outside the query state `driveHold` is 0.
- R4: The query state is left when the high-side inputs are all low and the low-side inputs are all high, stable for the window.
- R5: In the query state, with all high-side inputs high, driving only low-side input k low (`loCmd[k]`=0, k = 0, 1, 2) selects `causeBits[k]`. Bit 0 is the DC-bus-negative overcurrent, bit 1 the auxiliary overcurrent and bit 2 the ground fault. `faultPinLow` equals the selected bit.
- R6: In the query state, with all high-side inputs high and all low-side inputs low, `causeBits[3]` (logic-supply undervoltage) is selected and `faultPinLow` equals it.
- R7: In the query state, any command pattern other than the four query patterns leaves the fault pin released (`faultPinLow`=0). This includes patterns where any high-side input is low.
- R8: A command pattern held for fewer than `STABLE_CYC`-1 cycles has no effect on `faultPinLow` or `diagActive`. A pattern held for `STABLE_CYC` cycles or more is acted on.
- R9: Outside the query state `faultPinLow` follows `faultActive`. After reset `faultPinLow`=0, `diagActive`=0 and `driveHold`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| faultActive | input | 1 | A protection fault is currently latched |
| causeBits | input | NUM_PH+1 | Cause register: [0] DC- overcurrent, [1] auxiliary overcurrent, [2] ground fault, [3] logic-supply undervoltage |
| hiCmd | input | NUM_PH | High-side gate command inputs |
| loCmd | input | NUM_PH | Low-side gate command inputs |
| faultPinLow | output | 1 | 1 = pull the shared open-drain fault pin low |
| diagActive | output | 1 | Query state is active |
| driveHold | output | 1 | Force all gate outputs and the auxiliary output low, hold the clear-timer node low |

## Verification
Two functions can act at the same clock edge. A change of the filtered command pattern can update the answer on the fault pin in the same cycle that it moves the query state. A change in the cause bits can also land in the same cycle as a new query pattern. The bench sweeps every cause-register value against every command pattern except the exit pattern, while the engine stays in the query state. Each step changes pattern and causes together, so the answer must reflect the new pair and never the old one. Entry, exit and the stability window are then driven at their edges: an entry without a fault, a glitch two cycles shorter than the window, and a hold longer than the window. After each, the pin and state flags are compared with values computed from the pattern table.

// File: rtl/fault_query_pkg.sv
package fault_query_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic holdOff;   // query state active: outputs held off, no fault echo
    logic answerEn;  // query state and high-side all high: answer a cause query
  } query_ctl_t;

  typedef enum logic {
    ST_RUN  = 1'b0,
    ST_DIAG = 1'b1
  } query_state_e;

endpackage

// File: rtl/fault_query_dp.sv
module fault_query_dp
  import fault_query_pkg::*;
#(
  parameter int NUM_PH     = 3,
  parameter int STABLE_CYC = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              faultActive,
  input  logic [NUM_PH:0]   causeBits,
  input  logic [NUM_PH-1:0] hiCmd,
  input  logic [NUM_PH-1:0] loCmd,
  input  query_ctl_t        ctl,
  output logic              patAllHigh,
  output logic              patLeave,
  output logic              patHiHigh,
  output logic              pinLowQ
);

  localparam int PAT_W = 2 * NUM_PH;
  localparam int CNT_W = (STABLE_CYC > 2) ? $clog2(STABLE_CYC) : 1;
  localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(STABLE_CYC - 1);

  logic [PAT_W-1:0] rawPat;
  logic [PAT_W-1:0] rawQ;
  logic [PAT_W-1:0] filtPat;
  logic [CNT_W-1:0] holdCnt;
  logic [NUM_PH-1:0] filtHi;
  logic [NUM_PH-1:0] filtLo;
  logic [NUM_PH:0]   selVec;
  logic              queryHit;

  assign rawPat = {hiCmd, loCmd};

  // Stability filter: a pattern passes only after STABLE_CYC unchanged samples
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rawQ    <= '0;
      holdCnt <= '0;
      filtPat <= '0;
    end else begin
      rawQ <= rawPat;
      if (rawPat != rawQ) begin
        holdCnt <= '0;
      end else if (holdCnt != CNT_TOP) begin
        holdCnt <= holdCnt + 1'b1;
      end
      if (holdCnt == CNT_TOP) begin
        filtPat <= rawQ;
      end
    end
  end

  assign filtHi = filtPat[PAT_W-1:NUM_PH];
  assign filtLo = filtPat[NUM_PH-1:0];

  assign patHiHigh  = &filtHi;
  assign patAllHigh = patHiHigh && (&filtLo);
  assign patLeave   = (filtHi == '0) && (&filtLo);

  // Query select: one-low patterns pick per-phase causes, all-low picks the supply bit
  genvar k;
  generate
    for (k = 0; k < NUM_PH; k++) begin : g_sel
      assign selVec[k] = patHiHigh && (filtLo == ~(NUM_PH'(1) << k));
    end
  endgenerate
  assign selVec[NUM_PH] = patHiHigh && (filtLo == '0);

  assign queryHit = |(selVec & causeBits);

  // Fault pin driver
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pinLowQ <= 1'b0;
    end else if (ctl.answerEn) begin
      pinLowQ <= queryHit;
    end else if (ctl.holdOff) begin
      pinLowQ <= 1'b0;
    end else begin
      pinLowQ <= faultActive;
    end
  end

  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(selVec)); // R5

  AST_FILTER_FROM_INPUT: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(filtPat) |-> (filtPat == $past(rawQ))); // R8

  AST_RELEASE_UNLISTED: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.holdOff && !patHiHigh) |=> !pinLowQ); // R7

endmodule

// File: rtl/fault_query_ctrl.sv
module fault_query_ctrl
  import fault_query_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       faultActive,
  input  logic       patAllHigh,
  input  logic       patLeave,
  input  logic       patHiHigh,
  output query_ctl_t ctl
);

  query_state_e state;
  query_state_e stateNxt;

  always_comb begin
    stateNxt = state;
    unique case (state)
      ST_RUN:  if (faultActive && patAllHigh) stateNxt = ST_DIAG;
      ST_DIAG: if (patLeave)                  stateNxt = ST_RUN;
      default: stateNxt = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_RUN;
    end else begin
      state <= stateNxt;
    end
  end

  assign ctl.holdOff  = (state == ST_DIAG);
  assign ctl.answerEn = (state == ST_DIAG) && patHiHigh;

  AST_ENTER_NEEDS_FAULT: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ctl.holdOff) |-> $past(faultActive)); // R1

  AST_ENTER_PATTERN: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ctl.holdOff) |-> $past(patAllHigh)); // R2

  AST_EXIT_PATTERN: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ctl.holdOff) |-> $past(patLeave)); // R4

endmodule

// File: rtl/fault_query_engine.sv
module fault_query_engine
  import fault_query_pkg::*;
#(
  parameter int NUM_PH     = 3,
  parameter int STABLE_CYC = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              faultActive,
  input  logic [NUM_PH:0]   causeBits,
  input  logic [NUM_PH-1:0] hiCmd,
  input  logic [NUM_PH-1:0] loCmd,
  output logic              faultPinLow,
  output logic              diagActive,
  output logic              driveHold
);

  query_ctl_t ctl;
  logic patAllHigh;
  logic patLeave;
  logic patHiHigh;
  logic pinLowQ;

  fault_query_dp #(
    .NUM_PH    (NUM_PH),
    .STABLE_CYC(STABLE_CYC)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .faultActive(faultActive),
    .causeBits  (causeBits),
    .hiCmd      (hiCmd),
    .loCmd      (loCmd),
    .ctl        (ctl),
    .patAllHigh (patAllHigh),
    .patLeave   (patLeave),
    .patHiHigh  (patHiHigh),
    .pinLowQ    (pinLowQ)
  );

  fault_query_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .faultActive(faultActive),
    .patAllHigh (patAllHigh),
    .patLeave   (patLeave),
    .patHiHigh  (patHiHigh),
    .ctl        (ctl)
  );

  assign faultPinLow = pinLowQ;
  assign diagActive  = ctl.holdOff;
  assign driveHold   = ctl.holdOff;

  AST_HOLD_IN_DIAG: assert property (@(posedge clk) disable iff (!rstN)
    diagActive |-> driveHold); // R3

endmodule

// File: tb/fault_query_engine_tb.sv
module fault_query_engine_tb;

  localparam int NUM_PH     = 3;
  localparam int STABLE_CYC = 4;
  localparam int SETTLE     = STABLE_CYC + 4;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              faultActive = 1'b0;
  logic [NUM_PH:0]   causeBits = '0;
  logic [NUM_PH-1:0] hiCmd = '0;
  logic [NUM_PH-1:0] loCmd = '0;
  logic              faultPinLow;
  logic              diagActive;
  logic              driveHold;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  fault_query_engine #(
    .NUM_PH    (NUM_PH),
    .STABLE_CYC(STABLE_CYC)
  ) u_dut (
    .clk        (clk),
    .rstN       (rstN),
    .faultActive(faultActive),
    .causeBits  (causeBits),
    .hiCmd      (hiCmd),
    .loCmd      (loCmd),
    .faultPinLow(faultPinLow),
    .diagActive (diagActive),
    .driveHold  (driveHold)
  );

  task automatic check(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0b exp=%0b t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic waitCyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic drive(input logic [NUM_PH-1:0] h, input logic [NUM_PH-1:0] l);
    hiCmd = h;
    loCmd = l;
  endtask

  // Expected answer in the query state, from the pattern table
  function automatic logic expAnswer(input logic [NUM_PH-1:0] h,
                                     input logic [NUM_PH-1:0] l,
                                     input logic [NUM_PH:0] c);
    if (h != '1) return 1'b0;
    if (l == '0) return c[NUM_PH];
    for (int k = 0; k < NUM_PH; k++)
      if (l == ~(NUM_PH'(1) << k)) return c[k];
    return 1'b0;
  endfunction

  initial begin
    waitCyc(200000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    waitCyc(3);
    rstN = 1'b1;
    waitCyc(1);
    // R9 reset state
    check("R9 reset pin", faultPinLow, 1'b0);
    check("R9 reset diag", diagActive, 1'b0);
    check("R9 reset hold", driveHold, 1'b0);

    // R9 pin follows fault outside query state
    faultActive = 1'b1;
    waitCyc(3);
    check("R9 pin follows fault=1", faultPinLow, 1'b1);
    faultActive = 1'b0;
    waitCyc(3);
    check("R9 pin follows fault=0", faultPinLow, 1'b0);

    // R1 no entry without a fault
    drive('1, '1);
    waitCyc(SETTLE);
    check("R1 no entry without fault", diagActive, 1'b0);
    check("R1 hold stays off", driveHold, 1'b0);

    // R2 entry with fault
    faultActive = 1'b1;
    waitCyc(SETTLE);
    check("R2 entry", diagActive, 1'b1);
    check("R3 hold in query", driveHold, 1'b1);
    check("R7 all-high released", faultPinLow, 1'b0);

    // R8 short glitch of a query pattern is ignored
    causeBits = 4'b0001;
    waitCyc(2);
    drive('1, 3'b110);
    waitCyc(STABLE_CYC - 2);
    check("R8 glitch pin during", faultPinLow, 1'b0);
    drive('1, '1);
    waitCyc(SETTLE);
    check("R8 glitch pin after", faultPinLow, 1'b0);
    drive('1, 3'b110);
    waitCyc(STABLE_CYC + 2);
    check("R8 long hold acted on", faultPinLow, 1'b1);

    // R8 short glitch of the exit pattern is ignored
    drive('0, '1);
    waitCyc(STABLE_CYC - 2);
    drive('1, '1);
    waitCyc(SETTLE);
    check("R8 exit glitch ignored", diagActive, 1'b1);

    // R5 R6 R7 sweep: every cause value against every non-exit pattern
    for (int c = 0; c < (1 << (NUM_PH + 1)); c++) begin
      for (int p = 0; p < (1 << (2 * NUM_PH)); p++) begin
        logic [NUM_PH-1:0] h;
        logic [NUM_PH-1:0] l;
        h = p[2*NUM_PH-1:NUM_PH];
        l = p[NUM_PH-1:0];
        if (!(h == '0 && l == '1)) begin
          causeBits = c[NUM_PH:0];
          drive(h, l);
          waitCyc(SETTLE);
          if (h == '1 && l == '0)
            check("R6 supply query", faultPinLow, expAnswer(h, l, causeBits));
          else if (h == '1 && $countones(~l) == 1)
            check("R5 phase query", faultPinLow, expAnswer(h, l, causeBits));
          else
            check("R7 unlisted released", faultPinLow, 1'b0);
          check("R3 hold during sweep", driveHold, 1'b1);
        end
      end
    end

    // R4 exit
    causeBits = 4'b1111;
    drive('0, '1);
    waitCyc(SETTLE);
    check("R4 exit diag", diagActive, 1'b0);
    check("R3 hold released", driveHold, 1'b0);
    check("R9 pin echoes fault after exit", faultPinLow, 1'b1);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule